// File: doc/BRIEF.md
# Chainable Dot-Matrix Driver Serial Loader

This block is the serial input stage of one LED dot-matrix driver that is built to sit in a chain of identical drivers. While the active-low chip enable is held low, every clock shifts one data bit in. A register-select input, taken once at the start of each enable window, decides where the bits go. They go either into a long shift register that holds pixel data or into a short shift register that holds command data. When the enable returns high, the command bits are copied into one of two control words. The top bit of the command decides which one.

A serial output passes data on to the next driver in the chain. By default it carries the bit that falls out of the end of whichever shift register is loading. This lets a chain of drivers act as one long register: two drivers give a 320-bit pixel register, and the second driver's bit 0 is chain bit 160. Setting the mode bit in control word 1 changes how command loads travel. In that mode the serial output copies the serial input directly during command loads, so one 8-clock command frame reaches every driver in the chain at the same time. In the default mode the same result takes 8 clocks per driver. Pixel loads always use the shift-through path.

Top module: `disp_serial_frontend`

## Requirements
- R1: After reset both control words read 0, the pixel register is all zeros and the serial output is 0; word 1 bit 0 = 0 means the default shift-through mode.
- R2: On every clock edge where chip enable (active low) is sampled low, the input bit enters bit 0 of the selected register and all other bits move up by one, so the first bit sent ends in the top position.
- R3: Register select is taken at the first clock of an enable window (1 = command register, 0 = pixel register). Changes to it later in the same window have no effect.
- R4: At the first clock where enable is seen high after a command window, a command register whose bit 7 = 0 is copied into control word 0.
- R5: In the same situation with bit 7 = 1, the command register is copied into control word 1 with bits 6 down to 2 forced to 0.
- R6: During a command load with word 1 bit 0 = 0, the serial output equals bit 7 of the command register.
- R7: During a command load with word 1 bit 0 = 1, the serial output equals the serial input in the same cycle, so a single 8-clock frame loads every chained driver.
- R8: During a pixel load the serial output equals the top bit (bit 159) of the pixel register, whatever the mode bit is.
- R9: A pixel window leaves both control words unchanged. A command window leaves the pixel register unchanged.
- R10: Two chained drivers act as one 320-bit pixel register. The first bit of a 320-bit stream lands in the second driver's bit 159, and the last bit lands in the first driver's bit 0.
- R11: While chip enable stays high, no register or control word changes, whatever the data and select inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ce_ni | input | 1 | Active-low chip enable framing a load |
| rsel_i | input | 1 | Register select: 1 command, 0 pixel |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out to the next driver |
| dot_o | output | DOT_W (160) | Pixel shift register contents |
| word0_o | output | CW (8) | Control word 0 |
| word1_o | output | CW (8) | Control word 1; bit 0 selects the cascade mode |

## Verification
Assertions check the following on every cycle:
- The register select latched for a window stays fixed while enable is held low.
- Each shift moves the sampled input bit into bit 0, and an idle register keeps its value.
- Control words change only on a latch cycle.
- A word-1 latch copies the command register's bit 0 into the mode bit.

Some behaviour only the bench scenarios can show. It drives two chained drivers:
- Command words of different lengths and modes, with the expected contents of each driver derived from how the bits travel between them.
- A 320-bit pixel stream that must land across both drivers.
- Cycle-by-cycle serial output that must follow the input in the broadcast mode and the register end otherwise.

// File: rtl/disp_pkg.sv
package disp_pkg;
    typedef enum logic {
        TGT_DOT  = 1'b0,
        TGT_CTRL = 1'b1
    } tgt_e;

    typedef struct packed {
        logic active;
        tgt_e tgt;
    } frame_st_t;
endpackage

// File: rtl/disp_frame_track.sv
module disp_frame_track
    import disp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_ni,
    input  logic rsel_i,
    output logic shift_o,
    output logic end_o,
    output tgt_e cur_tgt_o,
    output tgt_e frame_tgt_o
);
    frame_st_t st_d, st_q;
    logic      start;

    always_comb begin
        st_d        = st_q;
        start       = !ce_ni && !st_q.active;
        st_d.active = !ce_ni;
        if (start) begin
            st_d.tgt = rsel_i ? TGT_CTRL : TGT_DOT;
        end
        shift_o     = !ce_ni;
        end_o       = ce_ni && st_q.active;
        cur_tgt_o   = start ? (rsel_i ? TGT_CTRL : TGT_DOT) : st_q.tgt;
        frame_tgt_o = st_q.tgt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{active: 1'b0, tgt: TGT_DOT};
        end else begin
            st_q <= st_d;
        end
    end

    // Target chosen at window start holds for the whole window.
    assert_tgt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && !ce_ni) |=> $stable(st_q.tgt));
endmodule

// File: rtl/disp_shift_reg.sv
module disp_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] data;
    } sr_st_t;

    sr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.data = {st_q.data[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.data;

    assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (q_o[0] == $past(bit_i)));
    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(q_o));
endmodule

// File: rtl/disp_ctrl_words.sv
module disp_ctrl_words #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          latch_i,
    input  logic [CW-1:0] sr_i,
    output logic [CW-1:0] w0_o,
    output logic [CW-1:0] w1_o
);
    localparam int SEL_BIT = CW - 1;
    localparam int RSV_LO  = 2;
    localparam int RSV_HI  = CW - 2;

    typedef struct packed {
        logic [CW-1:0] w0;
        logic [CW-1:0] w1;
    } words_st_t;

    words_st_t st_d, st_q;
    logic [CW-1:0] rsv_mask;

    always_comb begin
        rsv_mask = '1;
        for (int i = RSV_LO; i <= RSV_HI; i++) begin
            rsv_mask[i] = 1'b0;
        end
        st_d = st_q;
        if (latch_i) begin
            if (sr_i[SEL_BIT]) begin
                st_d.w1 = sr_i & rsv_mask;
            end else begin
                st_d.w0 = sr_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign w0_o = st_q.w0;
    assign w1_o = st_q.w1;

    assert_word_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !latch_i |=> ($stable(w0_o) && $stable(w1_o)));
endmodule

// File: rtl/disp_serial_frontend.sv
module disp_serial_frontend #(
    parameter int DOT_W = 160,
    parameter int CW    = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_ni,
    input  logic             rsel_i,
    input  logic             din_i,
    output logic             dout_o,
    output logic [DOT_W-1:0] dot_o,
    output logic [CW-1:0]    word0_o,
    output logic [CW-1:0]    word1_o
);
    import disp_pkg::*;

    localparam int DOT_MSB  = DOT_W - 1;
    localparam int SEL_BIT  = CW - 1;
    localparam int MODE_BIT = 0;

    logic          shift, win_end, dot_en, ctrl_en, latch;
    tgt_e          cur_tgt, frame_tgt;
    logic [CW-1:0] csr;

    disp_frame_track u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ce_ni      (ce_ni),
        .rsel_i     (rsel_i),
        .shift_o    (shift),
        .end_o      (win_end),
        .cur_tgt_o  (cur_tgt),
        .frame_tgt_o(frame_tgt)
    );

    assign dot_en  = shift && (cur_tgt == TGT_DOT);
    assign ctrl_en = shift && (cur_tgt == TGT_CTRL);
    assign latch   = win_end && (frame_tgt == TGT_CTRL);

    disp_shift_reg #(.W(DOT_W)) u_dot_sr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (dot_en),
        .bit_i (din_i),
        .q_o   (dot_o)
    );

    disp_shift_reg #(.W(CW)) u_ctrl_sr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (ctrl_en),
        .bit_i (din_i),
        .q_o   (csr)
    );

    disp_ctrl_words #(.CW(CW)) u_words (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .latch_i(latch),
        .sr_i   (csr),
        .w0_o   (word0_o),
        .w1_o   (word1_o)
    );

    always_comb begin
        if (cur_tgt == TGT_CTRL) begin
            dout_o = word1_o[MODE_BIT] ? din_i : csr[SEL_BIT];
        end else begin
            dout_o = dot_o[DOT_MSB];
        end
    end

    assert_mode_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch && csr[SEL_BIT]) |=> (word1_o[MODE_BIT] == $past(csr[MODE_BIT])));
    assert_word0_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch && !csr[SEL_BIT]) |=> (word0_o == $past(csr)));
endmodule

// File: tb/test_disp_serial_frontend.sv
`timescale 1ns/1ps
module test_disp_serial_frontend;
    logic clk = 1'b0;
    logic rst_n;
    logic ce_n, rsel, din;
    logic dout_a, dout_b;
    logic [159:0] dot_a, dot_b;
    logic [7:0] w0_a, w1_a, w0_b, w1_b;

    always #2.5 clk = ~clk;

    disp_serial_frontend i_disp_serial_frontend (
        .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rsel_i(rsel), .din_i(din),
        .dout_o(dout_a), .dot_o(dot_a), .word0_o(w0_a), .word1_o(w1_a));

    disp_serial_frontend i_disp_serial_frontend_b (
        .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rsel_i(rsel), .din_i(dout_a),
        .dout_o(dout_b), .dot_o(dot_b), .word0_o(w0_b), .word1_o(w1_b));

    typedef struct {
        string        req;
        int           kind;
        logic [319:0] exp;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the two-driver chain
    logic [7:0]   m_a0, m_a1, m_b0, m_b1, m_asr, m_bsr;
    logic [319:0] m_chain;

    function automatic logic [319:0] actual(int kind);
        case (kind)
            0: return {312'd0, w0_a};
            1: return {312'd0, w1_a};
            2: return {312'd0, w0_b};
            3: return {312'd0, w1_b};
            4: return {dot_b, dot_a};
            5: return {319'd0, dout_a};
            default: return {319'd0, dout_b};
        endcase
    endfunction

    initial begin : monitor
        item_t it;
        logic [319:0] got;
        forever begin
            wait (sb.size() != 0);
            it = sb.pop_front();
            got = actual(it.kind);
            n_cmp++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, got, it.exp);
            end
        end
    end

    task automatic expect_val(string req, int kind, logic [319:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic check_all(string req);
        expect_val(req, 0, {312'd0, m_a0});
        expect_val(req, 1, {312'd0, m_a1});
        expect_val(req, 2, {312'd0, m_b0});
        expect_val(req, 3, {312'd0, m_b1});
        expect_val(req, 4, m_chain);
    endtask

    task automatic latch_model(inout logic [7:0] sr, inout logic [7:0] w0, inout logic [7:0] w1);
        if (sr[7]) w1 = sr & 8'h83;
        else       w0 = sr;
    endtask

    // one enable window; bits[n-1] goes first
    task automatic frame(input logic rs0, input int n, input logic [319:0] bits, input int flip_at);
        logic b, a_out, b_out, ea, eb;
        string rq;
        for (int j = 0; j < n; j++) begin
            b = bits[n-1-j];
            din = b;
            ce_n = 1'b0;
            rsel = (j == 0) ? rs0 : ((flip_at >= 0 && j >= flip_at) ? ~rs0 : rs0);
            if (rs0) begin
                a_out = m_a1[0] ? b : m_asr[7];
                b_out = m_b1[0] ? a_out : m_bsr[7];
                ea = a_out; eb = b_out;
                rq = m_a1[0] ? "R7" : "R6";
            end else begin
                ea = m_chain[159]; eb = m_chain[319];
                rq = "R8";
            end
            #0.5;
            expect_val(rq, 5, {319'd0, ea});
            expect_val(rq, 6, {319'd0, eb});
            @(posedge clk);
            if (rs0) begin
                m_bsr = {m_bsr[6:0], a_out};
                m_asr = {m_asr[6:0], b};
            end else begin
                m_chain = {m_chain[318:0], b};
            end
            @(negedge clk);
        end
        ce_n = 1'b1; din = 1'b0; rsel = 1'b0;
        @(posedge clk);
        if (rs0) begin
            latch_model(m_asr, m_a0, m_a1);
            latch_model(m_bsr, m_b0, m_b1);
        end
        @(negedge clk);
    endtask

    function automatic logic pat(int k);
        return (((k * 7) % 5) == 0) ^ ((k % 3) == 1);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        logic [319:0] stream;
        rst_n = 1'b0; ce_n = 1'b1; rsel = 1'b0; din = 1'b0;
        m_a0 = 0; m_a1 = 0; m_b0 = 0; m_b1 = 0; m_asr = 0; m_bsr = 0; m_chain = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1");
        expect_val("R1", 5, '0);
        expect_val("R1", 6, '0);
        // R4 serial mode, word 0 for each driver, far driver's word first
        frame(1'b1, 16, {304'd0, 8'h4A, 8'h35}, -1);
        check_all("R4");
        // R5 word 1 with reserved bits set
        frame(1'b1, 16, {304'd0, 8'hFD, 8'h82}, -1);
        check_all("R5");
        // R5 short frame: old command bits spill into the far driver
        frame(1'b1, 8, {312'd0, 8'h81}, -1);
        check_all("R5");
        // R7 broadcast: 8 clocks load both drivers
        frame(1'b1, 8, {312'd0, 8'h5C}, -1);
        check_all("R7");
        // R10 320-bit pixel stream across both drivers, mode bit set (R8)
        for (int k = 0; k < 320; k++) stream[319-k] = pat(k);
        frame(1'b0, 320, stream, -1);
        check_all("R10");
        // R3 select changes mid-window are ignored
        frame(1'b1, 8, {312'd0, 8'h11}, 3);
        check_all("R3");
        frame(1'b0, 4, {316'd0, 4'b1011}, 1);
        check_all("R3");
        // R11 idle clocks with inputs moving
        for (int k = 0; k < 6; k++) begin
            din = k[0]; rsel = k[1];
            @(negedge clk);
        end
        rsel = 1'b0; din = 1'b0;
        check_all("R11");
        // R9 command window leaves pixels alone; clears broadcast mode
        frame(1'b1, 8, {312'd0, 8'h80}, -1);
        check_all("R9");
        // R2 serial ordering across two drivers
        frame(1'b1, 16, {304'd0, 8'h83, 8'h27}, -1);
        check_all("R2");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule